// File: doc/BRIEF.md
# UART Receive Flow Control Unit

This unit drives the active-low request-to-send line of one UART channel and qualifies the channel's modem-status interrupt. Software programs an 8-bit control register through a simple write/read port. The register selects one of two modes. In the automatic mode, the unit compares the live receive-FIFO byte count against a programmed threshold and holds request-to-send inactive while the FIFO is too full. In the manual mode, request-to-send follows a software bit.

The same register holds an interrupt-enable bit. The unit watches the already-synchronized clear-to-send input for any change. While the enable is set, a change latches an interrupt request. The request stays latched until a one-cycle clear pulse removes it. The serializer, the FIFO storage and the transmit-side clear-to-send gating belong to neighbouring blocks.

The threshold table follows from the FIFO depth parameter. Code 0 selects depth minus one. Each higher code k selects depth minus k eighths of the depth.

Top module: `uart_rx_flow_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `rts_n` is 1, `modem_irq_en` is 0 and `modem_irq` is 0.
- R2: Register layout is trigger code in bits [7:5], automatic enable in bit 4, interrupt enable in bit 3, software RTS in bit 0. Bits [2:1] always read as 0, whatever was written, so writing 0xFF reads back 0xF9.
- R3: With bit 4 clear, `rts_n` is the inverse of bit 0: software RTS 1 gives `rts_n` 0, and software RTS 0 gives `rts_n` 1.
- R4: With bit 4 set, `rts_n` is 1 when the FIFO count is at or above the threshold for the trigger code. With the default 64-byte depth the thresholds are 0→63, 1→56, 2→48, 3→40, 4→32, 5→24, 6→16 and 7→8.
- R5: With bit 4 set, `rts_n` returns to 0 as soon as the FIFO count falls below the threshold.
- R6: With bit 4 set, the software RTS bit has no effect on `rts_n`.
- R7: `rts_n` is registered. It reflects a new FIFO count on the first rising edge after the count changes. It reflects a register write on the second rising edge after the write strobe is sampled.
- R8: `modem_irq_en` always equals register bit 3.
- R9: A change of `cts_n_sync` in either direction sets `modem_irq` on the next rising edge, but only while bit 3 is set. With bit 3 clear, a change leaves `modem_irq` at 0.
- R10: `modem_irq` holds until `irq_clr` is sampled high. If a clear and a qualified change arrive in the same cycle, `modem_irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_fill | input | 7 | Current receive-FIFO byte count, 0..64 |
| cts_n_sync | input | 1 | Synchronized active-low clear-to-send |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| modem_irq_en | output | 1 | Modem interrupt enable qualifier |
| modem_irq | output | 1 | Latched modem-status interrupt request |

## Verification
Two events can land on the same edge: a software clear of the latched interrupt and a fresh qualified clear-to-send change. The bench drives `irq_clr` and a toggle of `cts_n_sync` on the same falling edge while the enable is set. It then checks that the request is still set after the next rising edge, so the new event is not lost. A second case can also coincide: a register write that switches mode while the FIFO count moves. The bench checks it by sampling `rts_n` one edge and two edges after the write. The two samples must show the old setting and then the new one.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

   typedef struct packed {
      logic [2:0] trig;
      logic       afc;
      logic       ien;
      logic [1:0] rsvd;
      logic       rts_sw;
   } mcr_t;

   localparam int unsigned NUM_CODES = 8;

   // Threshold for a trigger code: code 0 = one below full,
   // code k = depth minus k eighths of the depth.
   function automatic int unsigned trig_level(input int unsigned code,
                                              input int unsigned depth);
      if (code == 0) return depth - 1;
      return depth - code * (depth / NUM_CODES);
   endfunction

endpackage

// File: rtl/fc_ctrl_reg.sv
module fc_ctrl_reg
   import uart_fc_pkg::*;
#(
   parameter bit AUTO_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output mcr_t       mcr_q
);

   logic afc_w;
   logic rsvd_unused;

   assign rsvd_unused = ^wdata[2:1];

   generate
      if (AUTO_SUPPORT) begin : g_auto
         assign afc_w = wdata[4];
      end else begin : g_noauto
         logic afc_unused;
         assign afc_unused = wdata[4];
         assign afc_w      = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcr_q <= '0;
      end else if (wr_en) begin
         mcr_q.trig   <= wdata[7:5];
         mcr_q.afc    <= afc_w;
         mcr_q.ien    <= wdata[3];
         mcr_q.rsvd   <= 2'b00;
         mcr_q.rts_sw <= wdata[0];
      end
   end

endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen
   import uart_fc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       trig,
   input  logic             afc,
   input  logic             rts_sw,
   input  logic [CNT_W-1:0] rx_fill,
   output logic             rts_n
);

   logic [CNT_W-1:0] thr_tab [NUM_CODES];
   logic             level_hit;
   logic             rts_n_d;

   generate
      for (genvar g = 0; g < NUM_CODES; g++) begin : g_thr
         assign thr_tab[g] = CNT_W'(trig_level(g, FIFO_DEPTH));
      end
   endgenerate

   assign level_hit = (rx_fill >= thr_tab[trig]);

   always_comb begin
      if (afc) rts_n_d = level_hit;
      else     rts_n_d = ~rts_sw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rts_n <= 1'b1;
      else        rts_n <= rts_n_d;
   end

endmodule

// File: rtl/fc_cts_irq.sv
module fc_cts_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_n,
   input  logic ien,
   input  logic clr,
   output logic irq
);

   logic cts_q;
   logic change;

   assign change = (cts_n != cts_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_q <= 1'b1;
         irq   <= 1'b0;
      end else begin
         cts_q <= cts_n;
         if (change && ien) irq <= 1'b1;   // new event wins over clear
         else if (clr)      irq <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rx_flow_ctrl.sv
module uart_rx_flow_ctrl
   import uart_fc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH   = 64,
   parameter bit          AUTO_SUPPORT = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_wr_en,
   input  logic [7:0]                          reg_wdata,
   output logic [7:0]                          reg_rdata,
   input  logic [$clog2(FIFO_DEPTH + 1)-1:0]   rx_fill,
   input  logic                                cts_n_sync,
   input  logic                                irq_clr,
   output logic                                rts_n,
   output logic                                modem_irq_en,
   output logic                                modem_irq
);

   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if ((FIFO_DEPTH % NUM_CODES) != 0 || FIFO_DEPTH < 16) begin : g_bad_depth
         $error("FIFO_DEPTH must be a multiple of 8 and at least 16");
      end
   endgenerate

   mcr_t mcr_q;

   fc_ctrl_reg #(
      .AUTO_SUPPORT (AUTO_SUPPORT)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr_en),
      .wdata (reg_wdata),
      .mcr_q (mcr_q)
   );

   fc_rts_gen #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .CNT_W      (CNT_W)
   ) u_rts (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (mcr_q.trig),
      .afc     (mcr_q.afc),
      .rts_sw  (mcr_q.rts_sw),
      .rx_fill (rx_fill),
      .rts_n   (rts_n)
   );

   fc_cts_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cts_n (cts_n_sync),
      .ien   (mcr_q.ien),
      .clr   (irq_clr),
      .irq   (modem_irq)
   );

   assign reg_rdata    = {mcr_q.trig, mcr_q.afc, mcr_q.ien, 2'b00, mcr_q.rts_sw};
   assign modem_irq_en = mcr_q.ien;

endmodule

// File: rtl/uart_rx_flow_ctrl_chk.sv
module uart_rx_flow_ctrl_chk
   import uart_fc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       reg_rdata,
   input logic [CNT_W-1:0] rx_fill,
   input logic             irq_clr,
   input logic             rts_n,
   input logic             modem_irq_en,
   input logic             modem_irq
);

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2:1] == 2'b00);

   assert_manual_rts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_rdata[4]) |-> (rts_n == !$past(reg_rdata[0])));

   assert_auto_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rdata[4]) |->
         (rts_n == ($past(rx_fill) >=
                    CNT_W'(trig_level($past(reg_rdata[7:5]), FIFO_DEPTH)))));

   assert_ien_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
      modem_irq_en == reg_rdata[3]);

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(modem_irq) |-> $past(modem_irq_en));

   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (modem_irq && !irq_clr) |=> modem_irq);

endmodule

bind uart_rx_flow_ctrl uart_rx_flow_ctrl_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .CNT_W      (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_rdata    (reg_rdata),
   .rx_fill      (rx_fill),
   .irq_clr      (irq_clr),
   .rts_n        (rts_n),
   .modem_irq_en (modem_irq_en),
   .modem_irq    (modem_irq)
);

// File: tb/tb_uart_rx_flow_ctrl.sv
module tb_uart_rx_flow_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [6:0] rx_fill = 7'd0;
   logic       cts_n_sync = 1'b1;
   logic       irq_clr = 1'b0;
   logic       rts_n;
   logic       modem_irq_en;
   logic       modem_irq;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_rx_flow_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr_en    (reg_wr_en),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .rx_fill      (rx_fill),
      .cts_n_sync   (cts_n_sync),
      .irq_clr      (irq_clr),
      .rts_n        (rts_n),
      .modem_irq_en (modem_irq_en),
      .modem_irq    (modem_irq)
   );

   function automatic int level_of(input int code);
      case (code)
         0: return 63;
         1: return 56;
         2: return 48;
         3: return 40;
         4: return 32;
         5: return 24;
         6: return 16;
         default: return 8;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input int actual, input int expected);
      n_run++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   // Write strobe at a falling edge; register updated after the next rising edge.
   task automatic write_reg(input logic [7:0] v);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = 8'h00;
   endtask

   task automatic set_fill(input int f);
      rx_fill = 7'(f);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1", "rdata", reg_rdata, 8'h00);
      check("R1", "rts_n", rts_n, 1);
      check("R1", "irq_en", modem_irq_en, 0);
      check("R1", "irq", modem_irq, 0);
   endtask

   task automatic t_readback();
      write_reg(8'hFF);
      check("R2", "rdata after 0xFF", reg_rdata, 8'hF9);
      write_reg(8'h06);
      check("R2", "rdata after 0x06", reg_rdata, 8'h00);
      write_reg(8'hA9);
      check("R2", "rdata after 0xA9", reg_rdata, 8'hA9);
      write_reg(8'h00);
   endtask

   task automatic t_manual();
      rx_fill = 7'd64;
      write_reg(8'h01);
      @(negedge clk);
      check("R3", "sw=1 full fifo", rts_n, 0);
      write_reg(8'h00);
      @(negedge clk);
      check("R3", "sw=0", rts_n, 1);
      set_fill(0);
      check("R3", "sw=0 empty fifo", rts_n, 1);
   endtask

   task automatic t_auto_table();
      for (int c = 0; c < 8; c++) begin
         int lvl;
         lvl = level_of(c);
         rx_fill = 7'(lvl - 1);
         write_reg(8'((c << 5) | 8'h10));
         @(negedge clk);
         check("R5", $sformatf("code %0d below level", c), rts_n, 0);
         set_fill(lvl);
         check("R4", $sformatf("code %0d at level", c), rts_n, 1);
         set_fill(64);
         check("R4", $sformatf("code %0d full", c), rts_n, 1);
         set_fill(lvl - 1);
         check("R5", $sformatf("code %0d drained", c), rts_n, 0);
      end
   endtask

   task automatic t_override();
      rx_fill = 7'd40;
      write_reg(8'h71);               // code 3 (40), auto on, sw RTS 1
      @(negedge clk);
      check("R6", "auto at level sw=1", rts_n, 1);
      rx_fill = 7'd10;
      write_reg(8'h70);               // sw RTS 0, still auto
      @(negedge clk);
      check("R6", "auto below level sw=0", rts_n, 0);
   endtask

   task automatic t_timing();
      rx_fill = 7'd0;
      write_reg(8'h00);
      @(negedge clk);
      check("R7", "start high", rts_n, 1);
      write_reg(8'h01);
      check("R7", "one edge after write", rts_n, 1);
      @(negedge clk);
      check("R7", "two edges after write", rts_n, 0);
      write_reg(8'hF0);               // auto, code 7 (8 bytes)
      @(negedge clk);
      rx_fill = 7'd8;
      #1;
      check("R7", "before edge", rts_n, 0);
      @(negedge clk);
      check("R7", "one edge after fill", rts_n, 1);
      rx_fill = 7'd0;
      write_reg(8'h00);
      @(negedge clk);
   endtask

   task automatic t_irq_en();
      write_reg(8'h08);
      check("R8", "irq_en set", modem_irq_en, 1);
      write_reg(8'h00);
      check("R8", "irq_en clear", modem_irq_en, 0);
   endtask

   task automatic t_irq_events();
      cts_n_sync = 1'b0;              // change while disabled
      @(negedge clk);
      check("R9", "disabled change", modem_irq, 0);
      @(negedge clk);
      check("R9", "disabled later", modem_irq, 0);
      write_reg(8'h08);
      cts_n_sync = 1'b1;              // rising change
      @(negedge clk);
      check("R9", "rise sets", modem_irq, 1);
      repeat (3) @(negedge clk);
      check("R10", "held", modem_irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R10", "cleared", modem_irq, 0);
      cts_n_sync = 1'b0;              // falling change
      @(negedge clk);
      check("R9", "fall sets", modem_irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R10", "cleared again", modem_irq, 0);
   endtask

   task automatic t_irq_collide();
      cts_n_sync = 1'b1;
      @(negedge clk);
      check("R10", "preset", modem_irq, 1);
      irq_clr = 1'b1;
      cts_n_sync = 1'b0;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R10", "clear with new change", modem_irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R10", "clear alone", modem_irq, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_manual();
      t_auto_table();
      t_override();
      t_timing();
      t_irq_en();
      t_irq_events();
      t_irq_collide();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule